// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a byte-wide serial memory that sits on a four-wire serial bus in clock mode 0 or 3. It runs entirely on the system clock. The bus pins (serial clock, active-low select, data in and active-low write guard) pass through two-flop synchronizers, and serial clock edges are found in the system clock domain. Each select frame begins with a one-byte command. The command can be followed by an address byte, a status byte or data bytes. For the two array commands, the ninth address bit is carried in bit 3 of the command byte.

The block keeps a status byte. It holds a busy flag, a write-enable latch and two protection bits that fence off the top quarter, the top half or all of the array. Reads come straight from an inferred 512x8 array. Writes are first collected in a page buffer. When select rises on a byte boundary, the block emits a single request pulse to an external page-write engine and holds its busy flag until that engine has raised and then dropped its busy line. During that time the buffered bytes are copied into the array. A status write is handed to the engine the same way, and its new protection bits take effect only when that cycle ends.

Top module: `ee_spi_front`

## Requirements
- R1: A command byte is accepted only if bits 7..4 are zero. Its bits 2..0 select the command: 110 enable writes, 100 disable writes, 101 read status, 001 write status, 011 read array, 010 write array. Bit 3 is address bit 8 for the two array commands and is ignored for the others.
- R2: A command byte with a non-zero upper nibble, or with bits 2..0 equal to 000 or 111, makes the block ignore every further bit until select rises.
- R3: The status byte reads as {1,1,1,1,BP1,BP0,WEL,BUSY} from bit 7 down to bit 0. It can be read during a write cycle, and it repeats for as long as clocking continues within one frame.
- R4: WEL is set by the enable command. It is cleared by reset, by the disable command, by the end of any write cycle, and continuously while the write-guard pin is low.
- R5: Status write and array write are refused when WEL is 0, when a write cycle is in progress, or when the write guard is low. A refused command issues no request.
- R6: An array write is refused when its address is protected: nothing for BP=00, 180h-1FFh for 01, 100h-1FFh for 10, and the whole array for 11.
- R7: An array read is refused while a write cycle is in progress, and the data line then stays 0. Otherwise it returns bytes from the start address upward, wrapping from 1FFh to 000h, for as long as select stays low.
- R8: The data bytes of one array write land at consecutive addresses that wrap within the aligned 16-byte page. All of them are committed by one write cycle.
- R9: An array write is committed only if select rises after a whole number of data bytes (at least one). A status write is committed only if select rises after exactly one data byte and before any further rising clock edge.
- R10: After a status write, the protection bits and the status readback keep their old values until the write cycle ends, and then take the new bits 3..2 of the data byte.
- R11: The output enable is high only while the synchronized select is low. Output data is MSB first and changes only after a falling serial clock edge.
- R12: Each commit raises a one-cycle request with a kind flag (1 = status write) and the page base address. BUSY stays 1 from the commit until the engine has raised its busy input and then lowered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the bus master (asynchronous) |
| csn_i | input | 1 | Active-low select (asynchronous) |
| mosi_i | input | 1 | Serial data in, sampled on rising serial clock |
| wpn_i | input | 1 | Active-low write guard |
| eng_busy_i | input | 1 | Page-write engine busy |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the data-out pad |
| eng_req_o | output | 1 | One-cycle write request to the engine |
| eng_stat_o | output | 1 | Request kind: 1 for status write, 0 for array page |
| eng_addr_o | output | 9 | Page base address of the request |

## Verification
The assertions assume that the bus master holds each serial clock level for several system clocks, so that every edge survives the two-flop synchronizer and is seen exactly once. They also assume that the engine raises its busy line only after a request. The bench keeps each clock phase six system cycles long and keeps select high for at least ten cycles between frames. Its engine model raises busy in the cycle after a request and holds it for a fixed time. Every read-back expectation uses array locations that the bench wrote earlier, so refused and accepted writes can be told apart.

// File: rtl/ee_pkg.sv
// Shared definitions for the serial EEPROM command front end.
// Assumes a command byte layout of 0000_Accc (A = address bit 8).
package ee_pkg;

    typedef enum logic [3:0] {
        S_CMD,   // waiting for the command byte
        S_IGN,   // discard bits until select rises
        S_RADR,  // array read, address byte
        S_WADR,  // array write, address byte
        S_RD,    // array read, streaming data out
        S_WR,    // array write, collecting data bytes
        S_STAT,  // status read, streaming status out
        S_WSR,   // status write, data byte
        S_WSRD   // status write, byte received, waiting for select rise
    } fe_state_t;

    localparam logic [2:0] C_WEN  = 3'b110;
    localparam logic [2:0] C_WDIS = 3'b100;
    localparam logic [2:0] C_RSTA = 3'b101;
    localparam logic [2:0] C_WSTA = 3'b001;
    localparam logic [2:0] C_READ = 3'b011;
    localparam logic [2:0] C_WRIT = 3'b010;

endpackage

// File: rtl/pin_sync.sv
// Two-flop synchronizer for a group of asynchronous pins.
// Assumes each pin is stable for several clocks; RST gives the per-bit reset level.
module pin_sync #(
    parameter int          W   = 4,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // two-stage capture of one pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST[i];
                s2 <= RST[i];
            end else begin
                s1 <= d_i[i];
                s2 <= s1;
            end
        end
        assign q_o[i] = s2;
    end
endmodule

// File: rtl/blk_guard.sv
// Decides whether an array address lies in the region fenced by the two
// protection bits. Assumes the region grows downward from the top address.
module blk_guard #(
    parameter int AW = 9
) (
    input  logic [1:0]    bp_i,
    input  logic [AW-1:0] addr_i,
    output logic          prot_o
);
    // region decode from the protection level
    always_comb begin
        unique case (bp_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = &addr_i[AW-1:AW-2];
            2'b10:   prot_o = addr_i[AW-1];
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ee_spi_front.sv
// Serial EEPROM command front end: decodes commands from synchronized bus
// pins, keeps the status byte, serves reads from the array and hands page
// writes to an external engine. Assumes each serial clock phase lasts at
// least three system clocks. DEPTH must be 256 or 512.
module ee_spi_front #(
    parameter int DEPTH = 512,
    parameter int PAGE  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck_i,
    input  logic                     csn_i,
    input  logic                     mosi_i,
    input  logic                     wpn_i,
    input  logic                     eng_busy_i,
    output logic                     miso_o,
    output logic                     miso_oe_o,
    output logic                     eng_req_o,
    output logic                     eng_stat_o,
    output logic [$clog2(DEPTH)-1:0] eng_addr_o
);
    import ee_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);
    localparam logic [PW:0] DRAIN_END = PW'(0) | (PW+1)'(PAGE);

    logic [3:0] pins_s;
    logic       sck_s, csn_s, mosi_s, wpn_s, sck_d, csn_d;
    logic       sck_rise, sck_fall, cs_rise, cs_fall, byte_done;

    fe_state_t  st;
    logic [2:0] bitcnt;
    logic [6:0] shreg;
    logic [7:0] rx_byte, out_sh, rd_data, stat_byte;
    logic       a8_q, have_data, miso_q;
    logic [AW-1:0] addr_q, addr_in, rd_sel;
    logic [1:0] wsr_val, bp_q, bp_new;
    logic       wel_q, wip_q, req_q, pend_stat, seen_busy, prot, can_wr;
    logic       commit_stat, commit_arr, done;
    logic [PW:0] drain_cnt;
    logic [AW-PW-1:0] page_q;
    logic [7:0] mem  [DEPTH];
    logic [7:0] pbuf [PAGE];
    logic [PAGE-1:0] pval;

    pin_sync #(.W(4), .RST(4'b0101)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({sck_i, csn_i, mosi_i, wpn_i}), .q_o(pins_s)
    );
    assign {sck_s, csn_s, mosi_s, wpn_s} = pins_s;

    blk_guard #(.AW(AW)) u_guard (.bp_i(bp_q), .addr_i(addr_in), .prot_o(prot));

    // previous-level registers for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    assign sck_rise  = sck_s & ~sck_d & ~csn_s;
    assign sck_fall  = ~sck_s & sck_d & ~csn_s;
    assign cs_rise   = csn_s & ~csn_d;
    assign cs_fall   = ~csn_s & csn_d;
    assign byte_done = sck_rise & (bitcnt == 3'd7);
    assign rx_byte   = {shreg, mosi_s};
    assign addr_in   = AW'({a8_q, rx_byte});
    assign rd_sel    = (st == S_RADR) ? addr_in : addr_q;
    assign rd_data   = mem[rd_sel];
    assign stat_byte = {4'hF, bp_q, wel_q, wip_q};
    assign can_wr    = wel_q & ~wip_q & wpn_s;

    // frame state machine: shifting, decoding, addressing and output loading
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_CMD; bitcnt <= '0; shreg <= '0; a8_q <= 1'b0;
            addr_q <= '0; out_sh <= '0; have_data <= 1'b0; wsr_val <= '0;
        end else if (cs_rise || cs_fall) begin
            st <= S_CMD; bitcnt <= '0; have_data <= 1'b0;
        end else if (sck_rise) begin
            bitcnt <= bitcnt + 3'd1;
            shreg  <= {shreg[5:0], mosi_s};
            if (st == S_WSRD) begin
                st <= S_IGN;
            end else if (bitcnt == 3'd7) begin
                unique case (st)
                    S_CMD: begin
                        a8_q <= rx_byte[3];
                        if (rx_byte[7:4] != 4'd0) st <= S_IGN;
                        else begin
                            unique case (rx_byte[2:0])
                                C_RSTA: begin st <= S_STAT; out_sh <= stat_byte; end
                                C_WSTA: st <= can_wr ? S_WSR : S_IGN;
                                C_READ: st <= wip_q ? S_IGN : S_RADR;
                                C_WRIT: st <= can_wr ? S_WADR : S_IGN;
                                default: st <= S_IGN;
                            endcase
                        end
                    end
                    S_RADR: begin st <= S_RD; out_sh <= rd_data; addr_q <= addr_in + 1'b1; end
                    S_WADR: begin st <= prot ? S_IGN : S_WR; addr_q <= addr_in; end
                    S_WR: begin
                        have_data <= 1'b1;
                        addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
                    end
                    S_RD:   begin out_sh <= rd_data; addr_q <= addr_q + 1'b1; end
                    S_STAT: out_sh <= stat_byte;
                    S_WSR:  begin st <= S_WSRD; wsr_val <= rx_byte[3:2]; end
                    default: ;
                endcase
            end
        end else if (sck_fall && (st == S_RD || st == S_STAT)) begin
            out_sh <= {out_sh[6:0], 1'b0};
        end
    end

    // serial output bit, updated after a falling clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) miso_q <= 1'b0;
        else if (cs_rise || cs_fall) miso_q <= 1'b0;
        else if (sck_fall && (st == S_RD || st == S_STAT)) miso_q <= out_sh[7];
    end

    // page buffer fill during an array write frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pval <= '0; page_q <= '0;
        end else if (byte_done && st == S_WADR) begin
            pval <= '0; page_q <= addr_in[AW-1:PW];
        end else if (byte_done && st == S_WR) begin
            pbuf[addr_q[PW-1:0]] <= rx_byte;
            pval[addr_q[PW-1:0]] <= 1'b1;
        end
    end

    assign commit_stat = cs_rise & (st == S_WSRD) & can_wr;
    assign commit_arr  = cs_rise & (st == S_WR) & have_data & (bitcnt == 3'd0) & can_wr;
    assign done = wip_q & ~req_q & seen_busy & ~eng_busy_i & (drain_cnt == DRAIN_END);

    // write cycle tracking, request pulse and deferred protection update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip_q <= 1'b0; req_q <= 1'b0; pend_stat <= 1'b0; seen_busy <= 1'b0;
            bp_q <= '0; bp_new <= '0; drain_cnt <= DRAIN_END;
        end else begin
            req_q <= 1'b0;
            if (commit_stat || commit_arr) begin
                wip_q <= 1'b1; req_q <= 1'b1; pend_stat <= commit_stat;
                bp_new <= wsr_val; seen_busy <= 1'b0;
                drain_cnt <= commit_arr ? '0 : DRAIN_END;
            end else if (wip_q) begin
                if (eng_busy_i) seen_busy <= 1'b1;
                if (drain_cnt != DRAIN_END) drain_cnt <= drain_cnt + 1'b1;
                if (done) begin
                    wip_q <= 1'b0;
                    if (pend_stat) bp_q <= bp_new;
                end
            end
        end
    end

    // array update: copy staged page bytes during the write cycle
    always_ff @(posedge clk) begin
        if (wip_q && drain_cnt != DRAIN_END && pval[drain_cnt[PW-1:0]])
            mem[{page_q, drain_cnt[PW-1:0]}] <= pbuf[drain_cnt[PW-1:0]];
    end

    // write-enable latch set and clear events
    always_ff @(posedge clk) begin
        if (!rst_n) wel_q <= 1'b0;
        else if (!wpn_s || done) wel_q <= 1'b0;
        else if (byte_done && st == S_CMD && rx_byte[7:4] == 4'd0) begin
            if (rx_byte[2:0] == C_WEN) wel_q <= 1'b1;
            else if (rx_byte[2:0] == C_WDIS) wel_q <= 1'b0;
        end
    end

    assign miso_o     = miso_q;
    assign miso_oe_o  = ~csn_s;
    assign eng_req_o  = req_q;
    assign eng_stat_o = pend_stat;
    assign eng_addr_o = {page_q, PW'(0)};
endmodule

// File: rtl/ee_spi_front_chk.sv
// Property checker for ee_spi_front; attached by bind below.
// Assumes pins are held several clocks and the engine is well behaved.
module ee_spi_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csn_i,
    input logic       wpn_i,
    input logic       miso_oe_o,
    input logic       eng_req_o,
    input logic       wel_q,
    input logic       wip_q,
    input logic [1:0] bp_q
);
    a_r11_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !miso_oe_o);

    a_r4_guard_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wpn_i, 3) && !$past(wpn_i, 4)) |-> !wel_q);

    a_r12_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |=> !eng_req_o);

    a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |-> wip_q);

    a_r5_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |-> ($past(wel_q) && !$past(wip_q)));

    a_r10_bp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wip_q && $past(wip_q)) |-> $stable(bp_q));
endmodule

bind ee_spi_front ee_spi_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .wpn_i(wpn_i),
    .miso_oe_o(miso_oe_o), .eng_req_o(eng_req_o),
    .wel_q(wel_q), .wip_q(wip_q), .bp_q(bp_q)
);

// File: tb/ee_spi_front_bench.sv
// Directed bench for ee_spi_front: one task per scenario.
module ee_spi_front_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, wpn = 1'b1;
    logic eng_busy;
    logic miso, miso_oe, eng_req, eng_stat;
    logic [8:0] eng_addr;
    int checks = 0, fails = 0, reqs = 0, busy_cnt = 0;

    always #2 clk = ~clk;

    ee_spi_front u_ee_spi_front (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
        .wpn_i(wpn), .eng_busy_i(eng_busy), .miso_o(miso), .miso_oe_o(miso_oe),
        .eng_req_o(eng_req), .eng_stat_o(eng_stat), .eng_addr_o(eng_addr)
    );

    // engine model: busy for a fixed time after each request
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_busy <= 1'b0; busy_cnt <= 0;
        end else if (eng_req) begin
            eng_busy <= 1'b1; busy_cnt <= 300; reqs <= reqs + 1;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
            if (busy_cnt == 1) eng_busy <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        wt(2); csn = 1'b0; wt(6);
    endtask

    task automatic desel();
        wt(6); csn = 1'b1; wt(12);
    endtask

    task automatic xbit(input logic b, output logic r);
        mosi = b; wt(6); r = miso; sck = 1'b1; wt(6); sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
    endtask

    task automatic cmd1(input logic [7:0] c);
        logic [7:0] d;
        sel(); xfer(c, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    task automatic wr1(input logic [8:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer({4'h0, a[8], 3'b010}, d); xfer(a[7:0], d); xfer(v, d); desel();
    endtask

    task automatic rd1(input logic [8:0] a, output logic [7:0] v);
        logic [7:0] d;
        sel(); xfer({4'h0, a[8], 3'b011}, d); xfer(a[7:0], d); xfer(8'h00, v); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, d); xfer(v, d); desel();
    endtask

    task automatic idle();
        logic [7:0] s;
        for (int i = 0; i < 40; i++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic good_wr(input logic [8:0] a, input logic [7:0] v);
        cmd1(8'h06); wr1(a, v); idle();
    endtask

    task automatic t_reset();
        logic [7:0] s, s2, d;
        chk("R11 oe idle", {8'h0, miso_oe}, 9'h0);
        sel(); xfer(8'h05, d);
        chk("R11 oe selected", {8'h0, miso_oe}, 9'h1);
        xfer(8'h00, s); xfer(8'h00, s2); desel();
        chk("R3 reset status", {1'b0, s}, 9'h0F0);
        chk("R3 status repeats", {1'b0, s2}, 9'h0F0);
    endtask

    task automatic t_wel();
        logic [7:0] s;
        cmd1(8'h0E); rdsr(s); chk("R1 R4 enable (bit3 set)", {1'b0, s}, 9'h0F2);
        cmd1(8'h0C); rdsr(s); chk("R1 R4 disable (bit3 set)", {1'b0, s}, 9'h0F0);
    endtask

    task automatic t_preload();
        logic [7:0] v;
        good_wr(9'h1FF, 8'h77); good_wr(9'h000, 8'h88); good_wr(9'h0FF, 8'h66);
        good_wr(9'h180, 8'hAB); good_wr(9'h100, 8'hCD); good_wr(9'h020, 8'h44);
        chk("R12 request count", reqs[8:0], 9'd6);
        rd1(9'h0FF, v); chk("R1 low half address", {1'b0, v}, 9'h066);
    endtask

    task automatic t_write_busy();
        logic [7:0] s, v;
        cmd1(8'h06); wr1(9'h010, 8'h5A); rdsr(s);
        chk("R12 busy after commit", {1'b0, s}, 9'h0F3);
        chk("R12 kind array", {8'h0, eng_stat}, 9'h0);
        chk("R12 page base", eng_addr, 9'h010);
        idle(); rdsr(s);
        chk("R4 WEL cleared at end", {1'b0, s}, 9'h0F0);
        rd1(9'h010, v); chk("R8 single byte", {1'b0, v}, 9'h05A);
    endtask

    task automatic t_no_wel();
        logic [7:0] v; int r0;
        r0 = reqs; wr1(9'h010, 8'hA5); wt(20);
        chk("R5 no request without WEL", reqs[8:0], r0[8:0]);
        rd1(9'h010, v); chk("R5 data kept", {1'b0, v}, 9'h05A);
    endtask

    task automatic t_seq_read();
        logic [7:0] a, b, d;
        sel(); xfer(8'h0B, d); xfer(8'hFF, d); xfer(8'h00, a); xfer(8'h00, b); desel();
        chk("R7 R1 read 1FF", {1'b0, a}, 9'h077);
        chk("R7 wrap to 000", {1'b0, b}, 9'h088);
    endtask

    task automatic t_page();
        logic [7:0] d, a, b, c;
        cmd1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h1E, d); xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d); desel();
        idle();
        sel(); xfer(8'h03, d); xfer(8'h1E, d); xfer(8'h00, a); xfer(8'h00, b); desel();
        rd1(9'h010, c);
        chk("R8 page byte 1E", {1'b0, a}, 9'h011);
        chk("R8 page byte 1F", {1'b0, b}, 9'h022);
        chk("R8 page wrap to 10", {1'b0, c}, 9'h033);
    endtask

    task automatic t_read_busy();
        logic [7:0] v;
        cmd1(8'h06); wr1(9'h020, 8'h55); rd1(9'h020, v);
        chk("R7 read refused while busy", {1'b0, v}, 9'h000);
        idle(); rd1(9'h020, v);
        chk("R7 read after busy", {1'b0, v}, 9'h055);
    endtask

    task automatic t_protect();
        logic [7:0] s, v; int r0;
        cmd1(8'h06); wrsr(8'h0C); rdsr(s);
        chk("R10 old bits while busy", {1'b0, s}, 9'h0F3);
        chk("R12 kind status", {8'h0, eng_stat}, 9'h1);
        idle(); rdsr(s);
        chk("R10 new bits after end", {1'b0, s}, 9'h0FC);
        r0 = reqs; cmd1(8'h06); wr1(9'h010, 8'h99); wt(20);
        chk("R6 all protected", reqs[8:0], r0[8:0]);
        rd1(9'h010, v); chk("R6 all protected data", {1'b0, v}, 9'h033);
        cmd1(8'h04); cmd1(8'h06); wrsr(8'h04); idle();
        good_wr(9'h17F, 8'h12); rd1(9'h17F, v);
        chk("R6 quarter: 17F writable", {1'b0, v}, 9'h012);
        cmd1(8'h06); wr1(9'h180, 8'h34); wt(20); rd1(9'h180, v);
        chk("R6 quarter: 180 fenced", {1'b0, v}, 9'h0AB);
        cmd1(8'h04); cmd1(8'h06); wrsr(8'h08); idle();
        good_wr(9'h0FF, 8'h5C); rd1(9'h0FF, v);
        chk("R6 half: 0FF writable", {1'b0, v}, 9'h05C);
        cmd1(8'h06); wr1(9'h100, 8'h9E); wt(20); rd1(9'h100, v);
        chk("R6 half: 100 fenced", {1'b0, v}, 9'h0CD);
        cmd1(8'h04); cmd1(8'h06); wrsr(8'h00); idle();
    endtask

    task automatic t_guard();
        logic [7:0] s; int r0;
        cmd1(8'h06); wpn = 1'b0; wt(10); rdsr(s);
        chk("R4 guard low clears WEL", {1'b0, s}, 9'h0F0);
        r0 = reqs; cmd1(8'h06); wrsr(8'h0C); wt(20);
        chk("R5 guard low refuses", reqs[8:0], r0[8:0]);
        wpn = 1'b1; wt(10); rdsr(s);
        chk("R5 status unchanged", {1'b0, s}, 9'h0F0);
    endtask

    task automatic t_invalid();
        logic [7:0] s, d;
        sel(); xfer(8'h86, d); xfer(8'h06, d); desel(); rdsr(s);
        chk("R2 upper nibble rejects", {1'b0, s}, 9'h0F0);
        sel(); xfer(8'h07, d); xfer(8'h06, d); desel(); rdsr(s);
        chk("R2 code 111 ignored", {1'b0, s}, 9'h0F0);
    endtask

    task automatic t_partial();
        logic [7:0] s, d; logic r; int r0;
        r0 = reqs; cmd1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h40, d); xfer(8'h21, d);
        xbit(1'b0, r); xbit(1'b1, r); xbit(1'b0, r); desel();
        rdsr(s); chk("R9 mid-byte write dropped", {1'b0, s}, 9'h0F2);
        sel(); xfer(8'h01, d); xfer(8'h0C, d); xbit(1'b0, r); desel();
        rdsr(s); chk("R9 status write extra bit", {1'b0, s}, 9'h0F2);
        chk("R9 no request", reqs[8:0], r0[8:0]);
        cmd1(8'h04);
    endtask

    initial begin
        wt(5); rst_n = 1'b1; wt(5);
        t_reset(); t_wel(); t_preload(); t_write_busy(); t_no_wel();
        t_seq_read(); t_page(); t_read_busy(); t_protect(); t_guard();
        t_invalid(); t_partial();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule